// File: doc/BRIEF.md
# Serial UART with receiver standby and loopback

This block is a full-duplex asynchronous serial transmitter and receiver. It is steered by one 8-bit control register. The register selects 8-bit or 9-bit characters, the condition that ends receiver standby, internal loopback, where the looped receiver takes its input from, stop-in-wait behaviour, and the transmitter and receiver enables. Bit timing comes from an external tick enable that runs at 16 times the baud rate. The receiver samples three times around each bit's midpoint and takes the majority value.

Software puts the receiver into standby by setting the standby bit. While the bit is set, completed characters are not presented. Hardware clears the bit in one of two cases, chosen by the wake-select bit:
- the line stays idle for a full character time after traffic;
- a received character has its most significant data bit set. That character is delivered.

In loopback the external receive pin is ignored. The receiver listens either to the transmitter directly, with the transmit pin held at its idle level, or to the driven transmit pin path.

Top module: `sercom_wake_uart`

## Requirements
- R1: After reset the control register reads 0, `txd_pin` is high, `tx_ready` is low and `rx_valid` is low.
- R2: A character is a low start bit, then the data bits LSB first, then a high stop bit. There are 8 data bits when control bit 2 is 0 and 9 when it is 1. Each bit lasts 16 ticks of `baud_tick`.
- R3: When control bit 0 (loop) is 1, the receiver ignores `rxd_pin`.
- R4: With loop set and control bit 1 at 0, the receiver hears the transmitter internally, and `txd_pin` stays high throughout.
- R5: With loop set and control bit 1 at 1, the transmitter drives `txd_pin` and the receiver takes its input from that pin path.
- R6: With control bit 7 (standby) set and control bit 3 at 0, characters are not presented on `rx_valid`. Bit 7 clears once the line has been high for 10 bit times (8-bit) or 11 bit times (9-bit) after a character, and not before.
- R7: With bit 7 set and bit 3 at 1, a character whose most significant data bit (bit 7, or bit 8 in 9-bit mode) is 0 is dropped, and an idle line does not wake the receiver. A character whose most significant data bit is 1 clears bit 7 and is delivered.
- R8: When control bit 4 is 1 and `wait_mode` is high, `tx_ready` is low and incoming characters are lost. When bit 4 is 0, `wait_mode` has no effect.
- R9: A stop bit sampled low raises `rx_frame_err` in the same cycle as `rx_valid`, with the data still delivered.
- R10: Each received bit takes the majority of the samples at ticks 7, 8 and 9 of the bit. A start bit whose midpoint vote is high is abandoned without output.
- R11: Control bit 5 enables the transmitter: `tx_ready` is high only when bit 5 is set and no character is in flight. Control bit 6 enables the receiver; with it clear, nothing is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Enable pulse at 16x the baud rate |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_q | output | 8 | Current control register value |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | 9 | Transmit character (bit 8 used in 9-bit mode) |
| tx_ready | output | 1 | Transmitter accepts a character |
| rx_valid | output | 1 | One-cycle strobe: received character delivered |
| rx_data | output | 9 | Received character |
| rx_frame_err | output | 1 | Stop bit was low (valid with `rx_valid`) |
| rxd_pin | input | 1 | External serial input |
| txd_pin | output | 1 | Serial output |
| wait_mode | input | 1 | Chip wait-mode indication |

## Verification
The hardest case to reach from the ports is the idle-line wakeup boundary. The receiver must still be asleep partway through the idle window and awake after it, and the wakeup must not fire merely because the line was already idle when standby was entered. The bench sets standby only after a long quiet period and then sends one character. It reads the standby bit back through `cfg_q` at two points: one before and one after the 10-bit-time window measured from that character's stop bit. The address-mark case is covered in both character widths. A single-sample glitch at a data bit midpoint and a short false start exercise the voting.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

   localparam int unsigned CHAR_MAX_W = 9;

   typedef struct packed {
      logic sleep;      // bit 7: receiver standby
      logic rx_en;      // bit 6
      logic tx_en;      // bit 5
      logic stop_wait;  // bit 4
      logic wake_mark;  // bit 3: 1 = address mark wake, 0 = idle wake
      logic nine;       // bit 2: 9-bit characters
      logic rx_ext;     // bit 1: loop receiver from pin path
      logic loop;       // bit 0
   } ctrl_t;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/sercom_tx.sv
module sercom_tx
   import sercom_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  tick,
   input  logic                  nine,
   input  logic                  valid,
   input  logic [CHAR_MAX_W-1:0] data,
   output logic                  ready,
   output logic                  line
);
   localparam int unsigned CW = $clog2(OVERSAMPLE);
   localparam int unsigned FW = CHAR_MAX_W + 2;

   logic          busy;
   logic [FW-1:0] sh;
   logic [3:0]    left;
   logic [CW-1:0] cnt;

   assign ready = run && !busy;
   assign line  = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '1;
         left <= '0;
         cnt  <= '0;
      end else if (!run) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (valid) begin
            busy <= 1'b1;
            cnt  <= '0;
            left <= nine ? 4'd11 : 4'd10;
            sh   <= nine ? {1'b1, data, 1'b0} : {2'b11, data[7:0], 1'b0};
         end
      end else if (tick) begin
         if (cnt == CW'(OVERSAMPLE - 1)) begin
            cnt  <= '0;
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> !line);
   p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> !ready);

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
   import sercom_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter bit          VOTE3      = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  tick,
   input  logic                  nine,
   input  logic                  line,
   output logic                  done,
   output logic [CHAR_MAX_W-1:0] data,
   output logic                  ferr,
   output logic                  idle_hit
);
   localparam int unsigned CW       = $clog2(OVERSAMPLE);
   localparam int unsigned MID      = OVERSAMPLE / 2;
   localparam int unsigned IDLE_MAX = OVERSAMPLE * (CHAR_MAX_W + 2);
   localparam int unsigned IW       = $clog2(IDLE_MAX + 1);

   rx_state_e             st;
   logic [CW-1:0]         cnt;
   logic [3:0]            bidx;
   logic [CHAR_MAX_W-1:0] shreg;
   logic                  v_mid;
   logic                  bit_val;
   logic [IW-1:0]         idle_cnt;
   logic [IW-1:0]         idle_lim;

   assign idle_lim = nine ? IW'(OVERSAMPLE * 11) : IW'(OVERSAMPLE * 10);
   assign data     = shreg;

   generate
      if (VOTE3) begin : g_vote
         logic v_early;
         always_ff @(posedge clk) begin
            if (!rst_n) v_early <= 1'b1;
            else if (tick && cnt == CW'(MID - 1)) v_early <= line;
         end
         assign bit_val = vote3(v_early, v_mid, line);
      end else begin : g_single
         assign bit_val = v_mid;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         shreg    <= '0;
         v_mid    <= 1'b1;
         done     <= 1'b0;
         ferr     <= 1'b0;
         idle_hit <= 1'b0;
         idle_cnt <= '0;
      end else begin
         done     <= 1'b0;
         idle_hit <= 1'b0;
         if (!run) begin
            st       <= RX_IDLE;
            cnt      <= '0;
            idle_cnt <= '0;
         end else if (tick) begin
            if (st != RX_IDLE || !line) begin
               idle_cnt <= '0;
            end else if (idle_cnt < idle_lim) begin
               idle_cnt <= idle_cnt + IW'(1);
               if (idle_cnt == idle_lim - IW'(1)) idle_hit <= 1'b1;
            end
            if (st == RX_IDLE) begin
               if (!line) begin
                  st    <= RX_START;
                  cnt   <= CW'(1);
                  shreg <= '0;
               end
            end else begin
               cnt <= (cnt == CW'(OVERSAMPLE - 1)) ? '0 : cnt + CW'(1);
               if (cnt == CW'(MID)) v_mid <= line;
               if (cnt == CW'(MID + 1)) begin
                  case (st)
                     RX_START: if (bit_val) st <= RX_IDLE;
                     RX_DATA:  shreg[bidx] <= bit_val;
                     RX_STOP: begin
                        st   <= RX_IDLE;
                        done <= 1'b1;
                        ferr <= !bit_val;
                     end
                     default: ;
                  endcase
               end
               if (cnt == CW'(OVERSAMPLE - 1)) begin
                  case (st)
                     RX_START: begin
                        st   <= RX_DATA;
                        bidx <= '0;
                     end
                     RX_DATA: begin
                        if (bidx == (nine ? 4'd8 : 4'd7)) st <= RX_STOP;
                        else bidx <= bidx + 4'd1;
                     end
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   p_done_from_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (st == RX_IDLE) && ($past(st) == RX_STOP));
   p_start_needs_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE && run && tick && line) |=> (st == RX_IDLE));

endmodule

// File: rtl/sercom_ctrl.sv
module sercom_ctrl
   import sercom_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [7:0]            wdata,
   input  logic                  rx_done,
   input  logic [CHAR_MAX_W-1:0] rx_char,
   input  logic                  rx_ferr,
   input  logic                  idle_hit,
   output ctrl_t                 ctrl_q,
   output logic                  rx_valid,
   output logic [CHAR_MAX_W-1:0] rx_data,
   output logic                  rx_frame_err
);
   logic msb, mark_wake, idle_wake, deliver;

   assign msb       = ctrl_q.nine ? rx_char[8] : rx_char[7];
   assign mark_wake = rx_done && ctrl_q.sleep && ctrl_q.wake_mark && msb;
   assign idle_wake = idle_hit && ctrl_q.sleep && !ctrl_q.wake_mark;
   assign deliver   = rx_done && (!ctrl_q.sleep || mark_wake);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q       <= '0;
         rx_valid     <= 1'b0;
         rx_data      <= '0;
         rx_frame_err <= 1'b0;
      end else begin
         if (we) ctrl_q <= ctrl_t'(wdata);
         else if (mark_wake || idle_wake) ctrl_q.sleep <= 1'b0;
         rx_valid <= deliver;
         if (deliver) begin
            rx_data      <= rx_char;
            rx_frame_err <= rx_ferr;
         end else begin
            rx_frame_err <= 1'b0;
         end
      end
   end

   p_standby_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.sleep && !we && !rx_done && !idle_hit) |=> ctrl_q.sleep);
   p_asleep_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.sleep && !ctrl_q.wake_mark) |=> !rx_valid);

endmodule

// File: rtl/sercom_wake_uart.sv
module sercom_wake_uart
   import sercom_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter bit          VOTE3      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       cfg_we,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_q,
   input  logic       tx_valid,
   input  logic [8:0] tx_data,
   output logic       tx_ready,
   output logic       rx_valid,
   output logic [8:0] rx_data,
   output logic       rx_frame_err,
   input  logic       rxd_pin,
   output logic       txd_pin,
   input  logic       wait_mode
);
   generate
      if (OVERSAMPLE < 8) begin : g_bad_os
         $error("OVERSAMPLE must be at least 8");
      end
      if (OVERSAMPLE > 64) begin : g_big_os
         $error("OVERSAMPLE must not exceed 64");
      end
   endgenerate

   ctrl_t                 ctrl;
   logic                  active, tx_line, rx_line;
   logic                  rx_done, rx_ferr, idle_hit;
   logic [CHAR_MAX_W-1:0] rx_char;

   assign cfg_q   = ctrl;
   assign active  = !(ctrl.stop_wait && wait_mode);
   assign txd_pin = (ctrl.loop && !ctrl.rx_ext) ? 1'b1 : tx_line;
   assign rx_line = !ctrl.loop ? rxd_pin : (ctrl.rx_ext ? txd_pin : tx_line);

   sercom_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (active && ctrl.tx_en),
      .tick  (baud_tick),
      .nine  (ctrl.nine),
      .valid (tx_valid),
      .data  (tx_data),
      .ready (tx_ready),
      .line  (tx_line)
   );

   sercom_rx #(.OVERSAMPLE(OVERSAMPLE), .VOTE3(VOTE3)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (active && ctrl.rx_en),
      .tick     (baud_tick),
      .nine     (ctrl.nine),
      .line     (rx_line),
      .done     (rx_done),
      .data     (rx_char),
      .ferr     (rx_ferr),
      .idle_hit (idle_hit)
   );

   sercom_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (cfg_we),
      .wdata        (cfg_wdata),
      .rx_done      (rx_done),
      .rx_char      (rx_char),
      .rx_ferr      (rx_ferr),
      .idle_hit     (idle_hit),
      .ctrl_q       (ctrl),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_frame_err (rx_frame_err)
   );

   p_wait_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.stop_wait && wait_mode) |-> !tx_ready);

endmodule

// File: tb/sercom_wake_uart_bench.sv
`timescale 1ns/1ps
module sercom_wake_uart_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] div = '0;
   logic       baud_tick;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_q;
   logic       tx_valid = 1'b0;
   logic [8:0] tx_data = '0;
   logic       tx_ready;
   logic       rx_valid;
   logic [8:0] rx_data;
   logic       rx_frame_err;
   logic       rxd_pin = 1'b1;
   logic       txd_pin;
   logic       wait_mode = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [8:0] d;
      logic       fe;
      string      tag;
   } exp_t;
   exp_t expq[$];

   always #4 clk = ~clk;
   always_ff @(posedge clk) div <= div + 2'd1;
   assign baud_tick = (div == 2'd3);

   sercom_wake_uart u_sercom_wake_uart (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
      .rxd_pin(rxd_pin), .txd_pin(txd_pin), .wait_mode(wait_mode)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R3/R6/R7/R8/R10/R11", "unexpected rx_valid data", int'(rx_data), 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(rx_data == e.d, e.tag, "rx_data", int'(rx_data), int'(e.d));
            chk(rx_frame_err == e.fe, e.tag, "rx_frame_err", int'(rx_frame_err), int'(e.fe));
         end
      end
   end

   task automatic wait_ticks(input int n);
      repeat (n) @(posedge clk iff baud_tick);
      #1;
   endtask

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic expect_rx(input logic [8:0] d, input logic fe, input string tag);
      exp_t e;
      e.d = d; e.fe = fe; e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic drive_rx(input logic [8:0] d, input bit nine, input logic stop, input bit glitch);
      logic [10:0] fr;
      int n;
      n = nine ? 9 : 8;
      fr = '1;
      fr[0] = 1'b0;
      for (int i = 0; i < n; i++) fr[i+1] = d[i];
      fr[n+1] = stop;
      @(negedge clk);
      for (int b = 0; b < n + 2; b++) begin
         for (int t = 0; t < 16; t++) begin
            rxd_pin = fr[b] ^ (glitch && b == 4 && t == 8);
            wait_ticks(1);
         end
      end
      rxd_pin = 1'b1;
   endtask

   task automatic send_tx(input logic [8:0] d);
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data = d;
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
      #1 tx_valid = 1'b0;
   endtask

   task automatic capture_txd(input int n, output logic [10:0] fr);
      fr = '0;
      @(negedge clk);
      while (txd_pin) @(negedge clk);
      wait_ticks(8);
      fr[0] = txd_pin;
      for (int i = 1; i < n; i++) begin
         wait_ticks(16);
         fr[i] = txd_pin;
      end
   endtask

   task automatic drained(input string tag);
      chk(expq.size() == 0, tag, "characters still pending", expq.size(), 0);
      expq.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", "run did not finish", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [10:0] fr;
      int lows;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cfg_q == 8'h00, "R1", "cfg_q after reset", cfg_q, 0);
      chk(txd_pin == 1'b1, "R1", "txd_pin idle", txd_pin, 1);
      chk(tx_ready == 1'b0, "R1", "tx_ready after reset", tx_ready, 0);
      chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);

      // R11 enables gate
      write_cfg(8'h40);
      @(negedge clk);
      chk(tx_ready == 1'b0, "R11", "tx_ready with tx disabled", tx_ready, 0);
      write_cfg(8'h20);
      @(negedge clk);
      chk(tx_ready == 1'b1, "R11", "tx_ready with tx enabled", tx_ready, 1);
      drive_rx(9'h0AA, 1'b0, 1'b1, 1'b0);
      wait_ticks(40);
      drained("R11");

      // R2 receive 8-bit and 9-bit, transmit frames
      write_cfg(8'h60);
      expect_rx(9'h0A5, 1'b0, "R2");
      drive_rx(9'h0A5, 1'b0, 1'b1, 1'b0);
      wait_ticks(20);
      drained("R2");
      fork
         send_tx(9'h0A7);
         capture_txd(10, fr);
      join
      chk(fr[9:0] == {1'b1, 8'hA7, 1'b0}, "R2", "8-bit tx frame", int'(fr[9:0]), int'({1'b1, 8'hA7, 1'b0}));
      wait_ticks(40);
      write_cfg(8'h64);
      expect_rx(9'h1A5, 1'b0, "R2");
      drive_rx(9'h1A5, 1'b1, 1'b1, 1'b0);
      wait_ticks(20);
      drained("R2");
      fork
         send_tx(9'h155);
         capture_txd(11, fr);
      join
      chk(fr == {1'b1, 9'h155, 1'b0}, "R2", "9-bit tx frame", int'(fr), int'({1'b1, 9'h155, 1'b0}));
      wait_ticks(40);

      // R9 framing error
      write_cfg(8'h60);
      expect_rx(9'h07E, 1'b1, "R9");
      drive_rx(9'h07E, 1'b0, 1'b0, 1'b0);
      wait_ticks(60);
      drained("R9");

      // R10 false start and glitch vote
      @(negedge clk);
      rxd_pin = 1'b0;
      wait_ticks(4);
      rxd_pin = 1'b1;
      wait_ticks(40);
      drained("R10");
      expect_rx(9'h06B, 1'b0, "R10");
      drive_rx(9'h06B, 1'b0, 1'b1, 1'b0);
      expect_rx(9'h0C3, 1'b0, "R10");
      drive_rx(9'h0C3, 1'b0, 1'b1, 1'b1);
      wait_ticks(20);
      drained("R10");

      // R3/R4 internal loop, rxd_pin held low and ignored
      write_cfg(8'h61);
      rxd_pin = 1'b0;
      expect_rx(9'h03C, 1'b0, "R4");
      lows = 0;
      fork
         send_tx(9'h03C);
         repeat (700) @(negedge clk) if (!txd_pin) lows++;
      join
      chk(lows == 0, "R4", "txd_pin low cycles in internal loop", lows, 0);
      wait_ticks(20);
      drained("R3");

      // R5 loop through pin path
      write_cfg(8'h63);
      expect_rx(9'h05A, 1'b0, "R5");
      fork
         send_tx(9'h05A);
         capture_txd(10, fr);
      join
      chk(fr[9:0] == {1'b1, 8'h5A, 1'b0}, "R5", "frame on txd_pin", int'(fr[9:0]), int'({1'b1, 8'h5A, 1'b0}));
      wait_ticks(20);
      drained("R5");
      write_cfg(8'h60);
      rxd_pin = 1'b1;
      wait_ticks(200);

      // R6 idle-line wakeup
      write_cfg(8'hE0);
      drive_rx(9'h011, 1'b0, 1'b1, 1'b0);
      wait_ticks(80);
      @(negedge clk);
      chk(cfg_q[7] == 1'b1, "R6", "standby before idle window ends", cfg_q[7], 1);
      wait_ticks(90);
      @(negedge clk);
      chk(cfg_q[7] == 1'b0, "R6", "standby after idle window", cfg_q[7], 0);
      drained("R6");
      expect_rx(9'h022, 1'b0, "R6");
      drive_rx(9'h022, 1'b0, 1'b1, 1'b0);
      wait_ticks(200);
      drained("R6");

      // R7 address-mark wakeup, 8-bit
      write_cfg(8'hE8);
      drive_rx(9'h012, 1'b0, 1'b1, 1'b0);
      wait_ticks(200);
      @(negedge clk);
      chk(cfg_q[7] == 1'b1, "R7", "standby kept after idle and msb-0 char", cfg_q[7], 1);
      drained("R7");
      expect_rx(9'h093, 1'b0, "R7");
      drive_rx(9'h093, 1'b0, 1'b1, 1'b0);
      wait_ticks(20);
      @(negedge clk);
      chk(cfg_q[7] == 1'b0, "R7", "standby cleared by mark", cfg_q[7], 0);
      drained("R7");

      // R7 address-mark wakeup, 9-bit
      write_cfg(8'hEC);
      drive_rx(9'h0FF, 1'b1, 1'b1, 1'b0);
      wait_ticks(20);
      drained("R7");
      expect_rx(9'h100, 1'b0, "R7");
      drive_rx(9'h100, 1'b1, 1'b1, 1'b0);
      wait_ticks(20);
      @(negedge clk);
      chk(cfg_q[7] == 1'b0, "R7", "9-bit standby cleared by mark", cfg_q[7], 0);
      drained("R7");

      // R8 stop in wait
      write_cfg(8'h70);
      wait_mode = 1'b1;
      @(negedge clk);
      chk(tx_ready == 1'b0, "R8", "tx_ready in wait with stop bit", tx_ready, 0);
      drive_rx(9'h044, 1'b0, 1'b1, 1'b0);
      wait_ticks(40);
      drained("R8");
      wait_mode = 1'b0;
      @(negedge clk);
      chk(tx_ready == 1'b1, "R8", "tx_ready after wait ends", tx_ready, 1);
      write_cfg(8'h60);
      wait_mode = 1'b1;
      expect_rx(9'h045, 1'b0, "R8");
      drive_rx(9'h045, 1'b0, 1'b1, 1'b0);
      wait_ticks(20);
      chk(tx_ready == 1'b1, "R8", "tx_ready in wait without stop bit", tx_ready, 1);
      drained("R8");
      wait_mode = 1'b0;

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule